// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block watches a byte-wide receive stream of MAC frames, with the preamble already removed, and recognises IEEE 802.3x flow-control PAUSE frames. Each byte is checked as it goes past against the field it falls in: destination address, EtherType and opcode. The two pause-time bytes are kept. The source address is skipped. Nothing is buffered beyond a handful of match flags and the 16-bit pause time.

A detection is committed only at the end of the frame, and only when all of these hold: the frame's final status reports it good, the frame is long enough to hold every field, and both the full-duplex and flow-control enables are set. The block then raises a one-clock pulse and presents the captured pause time. A transmit scheduler uses that pulse to start its pause interval.

Top module: `fc_pause_detect`

## Requirements
- R1: A detection pulse is produced only when `full_duplex` and `flow_ctrl_en` are both 1 in the end-of-frame cycle. Clearing either one suppresses the pulse, and `pause_quanta` stays unchanged.
- R2: A destination address of 01:80:C2:00:00:01 is accepted. It is carried in byte offsets 0 to 5, first byte 0x01.
- R3: A destination address equal to `own_addr` is accepted, with `own_addr[47:40]` at offset 0 down to `own_addr[7:0]` at offset 5. Any other destination address, including one that differs only in the last byte, gives no pulse.
- R4: Bytes at offsets 6 to 11 (the source address) have no effect on detection.
- R5: The type field at offsets 12 and 13 must read 0x88 then 0x08, or no pulse is produced.
- R6: The opcode field at offsets 14 and 15 must read 0x00 then 0x01, or no pulse is produced.
- R7: Offset 16 (high byte) and offset 17 (low byte) form the pause time. Any value from 0x0000 to 0xFFFF is accepted. It appears on `pause_quanta` in the pulse cycle and is held until the next detection.
- R8: `rx_good` is sampled with the end-of-frame byte. If it is 0, no pulse is produced.
- R9: A frame whose end-of-frame byte sits before offset 17 gives no pulse. A longer frame, including one whose length passes the saturation point of the byte counter, is still detected.
- R10: After reset, `pause_hit` and `pause_quanta` are 0. `pause_hit` is high for exactly one clock, in the cycle after the end-of-frame byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` carries a byte this cycle |
| rx_sof | input | 1 | This byte is offset 0 of a frame |
| rx_eof | input | 1 | This byte is the last byte of the frame |
| rx_good | input | 1 | Frame status, valid with the end-of-frame byte |
| own_addr | input | 48 | Station unicast address, first-sent byte in bits 47:40 |
| full_duplex | input | 1 | Full-duplex mode enable |
| flow_ctrl_en | input | 1 | Flow-control enable |
| pause_hit | output | 1 | One-cycle PAUSE detection pulse |
| pause_quanta | output | 16 | Pause time of the last detected PAUSE frame |

## Verification
The bench builds the block with its default counter width of 6 bits, so the byte offset saturates at 63. That value sits well above the 18-byte header, and a 70-byte frame is enough to drive the counter into saturation and show that a long frame is still detected. With this width, every field offset, the short-frame cut-off at offset 17 and the saturation corner can all be reached with frames of realistic length.

// File: rtl/fc_pause_pkg.sv
package fc_pause_pkg;

    localparam logic [47:0] PAUSE_MC_DA   = 48'h0180_C200_0001;
    localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;

    localparam int DA_LEN   = 6;
    localparam int OFF_TYPE = 12;
    localparam int OFF_OPC  = 14;
    localparam int OFF_DUR  = 16;
    localparam int HDR_LEN  = 18;

    typedef struct packed {
        logic mc_da;
        logic own_da;
        logic type_ok;
        logic opc_ok;
    } fld_ok_t;

    localparam fld_ok_t FLD_ALL = 4'b1111;

    function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [2:0] k);
        logic [7:0] r;
        r = 8'h00;
        for (int b = 0; b < DA_LEN; b++) begin
            if (int'(k) == b) r = a[8*(DA_LEN-1-b) +: 8];
        end
        return r;
    endfunction

    function automatic logic frame_accept(input fld_ok_t f);
        return (f.mc_da | f.own_da) & f.type_ok & f.opc_ok;
    endfunction

endpackage

// File: rtl/fc_byte_index.sv
module fc_byte_index #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             byte_ok,
    output logic             frame_end,
    output logic [CNT_W-1:0] idx
);
    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    logic             in_frame_q;
    logic [CNT_W-1:0] idx_q;

    assign byte_ok   = rx_valid && (rx_sof || in_frame_q);
    assign frame_end = byte_ok && rx_eof;
    assign idx       = rx_sof ? '0 : idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
        end else if (byte_ok) begin
            in_frame_q <= !rx_eof;
            idx_q      <= (idx == IDX_MAX) ? idx : idx + 1'b1;
        end
    end
endmodule

// File: rtl/fc_field_check.sv
module fc_field_check
    import fc_pause_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_ok,
    input  logic             rx_sof,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       rx_data,
    input  logic [47:0]      own_addr,
    output fld_ok_t          ok_nxt,
    output logic [15:0]      dur_nxt
);
    fld_ok_t     ok_q;
    logic [15:0] dur_q;

    always_comb begin
        ok_nxt  = ok_q;
        dur_nxt = dur_q;
        if (byte_ok) begin
            if (rx_sof) ok_nxt = FLD_ALL;
            if (idx < CNT_W'(DA_LEN)) begin
                ok_nxt.mc_da  = ok_nxt.mc_da  & (rx_data == addr_byte(PAUSE_MC_DA, idx[2:0]));
                ok_nxt.own_da = ok_nxt.own_da & (rx_data == addr_byte(own_addr, idx[2:0]));
            end
            if (idx == CNT_W'(OFF_TYPE))
                ok_nxt.type_ok = ok_nxt.type_ok & (rx_data == MAC_CTRL_TYPE[15:8]);
            if (idx == CNT_W'(OFF_TYPE + 1))
                ok_nxt.type_ok = ok_nxt.type_ok & (rx_data == MAC_CTRL_TYPE[7:0]);
            if (idx == CNT_W'(OFF_OPC))
                ok_nxt.opc_ok = ok_nxt.opc_ok & (rx_data == PAUSE_OPCODE[15:8]);
            if (idx == CNT_W'(OFF_OPC + 1))
                ok_nxt.opc_ok = ok_nxt.opc_ok & (rx_data == PAUSE_OPCODE[7:0]);
            if (idx == CNT_W'(OFF_DUR))
                dur_nxt[15:8] = rx_data;
            if (idx == CNT_W'(OFF_DUR + 1))
                dur_nxt[7:0] = rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q  <= '0;
            dur_q <= '0;
        end else begin
            ok_q  <= ok_nxt;
            dur_q <= dur_nxt;
        end
    end
endmodule

// File: rtl/fc_commit.sv
module fc_commit
    import fc_pause_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] idx,
    input  fld_ok_t          ok_nxt,
    input  logic [15:0]      dur_nxt,
    input  logic             rx_good,
    input  logic             full_duplex,
    input  logic             flow_ctrl_en,
    output logic             pause_hit,
    output logic [15:0]      pause_quanta
);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_LEN - 1);

    logic accept;

    assign accept = frame_end && (idx >= LAST_HDR) && rx_good
                 && full_duplex && flow_ctrl_en && frame_accept(ok_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_hit    <= 1'b0;
            pause_quanta <= '0;
        end else begin
            pause_hit <= accept;
            if (accept) pause_quanta <= dur_nxt;
        end
    end
endmodule

// File: rtl/fc_pause_detect.sv
module fc_pause_detect
    import fc_pause_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_good,
    input  logic [47:0] own_addr,
    input  logic        full_duplex,
    input  logic        flow_ctrl_en,
    output logic        pause_hit,
    output logic [15:0] pause_quanta
);
    logic             byte_ok;
    logic             frame_end;
    logic [CNT_W-1:0] idx;
    fld_ok_t          ok_nxt;
    logic [15:0]      dur_nxt;

    fc_byte_index #(.CNT_W(CNT_W)) index_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .byte_ok(byte_ok), .frame_end(frame_end), .idx(idx)
    );

    fc_field_check #(.CNT_W(CNT_W)) check_i (
        .clk(clk), .rst(rst), .byte_ok(byte_ok), .rx_sof(rx_sof), .idx(idx),
        .rx_data(rx_data), .own_addr(own_addr), .ok_nxt(ok_nxt), .dur_nxt(dur_nxt)
    );

    fc_commit #(.CNT_W(CNT_W)) commit_i (
        .clk(clk), .rst(rst), .frame_end(frame_end), .idx(idx), .ok_nxt(ok_nxt),
        .dur_nxt(dur_nxt), .rx_good(rx_good), .full_duplex(full_duplex),
        .flow_ctrl_en(flow_ctrl_en), .pause_hit(pause_hit), .pause_quanta(pause_quanta)
    );
endmodule

// File: rtl/fc_pause_detect_chk.sv
module fc_pause_detect_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_eof,
    input logic        rx_good,
    input logic        full_duplex,
    input logic        flow_ctrl_en,
    input logic        pause_hit,
    input logic [15:0] pause_quanta
);
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pause_hit |=> !pause_hit);

    // R10
    after_eof_chk: assert property (@(posedge clk) disable iff (rst)
        pause_hit |-> $past(rx_valid && rx_eof));

    // R1
    enables_chk: assert property (@(posedge clk) disable iff (rst)
        pause_hit |-> $past(full_duplex && flow_ctrl_en));

    // R8
    good_status_chk: assert property (@(posedge clk) disable iff (rst)
        pause_hit |-> $past(rx_good));

    // R7
    quanta_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pause_hit |-> $stable(pause_quanta));
endmodule

bind fc_pause_detect fc_pause_detect_chk chk_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_good(rx_good),
    .full_duplex(full_duplex), .flow_ctrl_en(flow_ctrl_en),
    .pause_hit(pause_hit), .pause_quanta(pause_quanta)
);

// File: tb/fc_pause_detect_tb_top.sv
`timescale 1ns/100ps
module fc_pause_detect_tb_top;

    localparam logic [47:0] MC_DA  = 48'h0180_C200_0001;
    localparam logic [47:0] OWN_DA = 48'h021B_3C4D_5E6F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
    logic [47:0] own_addr = OWN_DA;
    logic        full_duplex = 1'b0, flow_ctrl_en = 1'b0;
    logic        pause_hit;
    logic [15:0] pause_quanta;

    always #2.5 clk = ~clk;

    fc_pause_detect dut_i (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good), .own_addr(own_addr),
        .full_duplex(full_duplex), .flow_ctrl_en(flow_ctrl_en),
        .pause_hit(pause_hit), .pause_quanta(pause_quanta)
    );

    typedef struct {
        logic        hit;
        logic [15:0] q;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          vectors = 0;
    int          errs = 0;
    int          chk = 0;
    bit          done = 1'b0;
    logic [15:0] last_q = '0;
    int          frame_no = 0;

    function automatic logic [7:0] byte_at(input int i, input logic [47:0] da,
        input logic [47:0] sa, input logic [15:0] typ, input logic [15:0] opc,
        input logic [15:0] dur);
        if (i < 6)  return da[8*(5-i) +: 8];
        if (i < 12) return sa[8*(11-i) +: 8];
        if (i < 14) return typ[8*(13-i) +: 8];
        if (i < 16) return opc[8*(15-i) +: 8];
        if (i < 18) return dur[8*(17-i) +: 8];
        return 8'(i);
    endfunction

    task automatic send_frame(input logic [47:0] da, input logic [15:0] typ,
        input logic [15:0] opc, input logic [15:0] dur, input int len,
        input logic good, input logic fd, input logic fce, input bit exp_hit,
        input string req);
        exp_t        e;
        logic [47:0] sa;
        frame_no++;
        sa = {16'hA5C3, 32'(frame_no) * 32'h0101_0101};
        if (exp_hit) last_q = dur;
        e.hit = exp_hit;
        e.q   = last_q;
        e.req = req;
        sb.push_back(e);
        full_duplex  = fd;
        flow_ctrl_en = fce;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_good  = (i == len - 1) ? good : 1'b0;
            rx_data  = byte_at(i, da, sa, typ, opc, dur);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
        chk = 1;
        @(negedge clk);
        chk = 2;
        @(negedge clk);
        chk = 0;
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (chk == 1) begin
                vectors++;
                if (sb.size() == 0) begin
                    errs++;
                    $display("FAIL scoreboard empty: actual hit=%0b expected item missing", pause_hit);
                end else begin
                    e = sb.pop_front();
                    if (pause_hit !== e.hit || pause_quanta !== e.q) begin
                        errs++;
                        $display("FAIL %s: actual hit=%0b quanta=%h expected hit=%0b quanta=%h",
                                 e.req, pause_hit, pause_quanta, e.hit, e.q);
                    end
                end
            end else if (chk == 2) begin
                vectors++;
                if (pause_hit !== 1'b0) begin
                    errs++;
                    $display("FAIL R10 pulse width: actual hit=%0b expected 0", pause_hit);
                end
            end else if (!rst && pause_hit === 1'b1) begin
                errs++;
                $display("FAIL R10 stray pulse: actual hit=1 expected 0");
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        vectors++;
        if (pause_hit !== 1'b0 || pause_quanta !== 16'h0) begin
            errs++;
            $display("FAIL R10 reset: actual hit=%0b quanta=%h expected 0/0000", pause_hit, pause_quanta);
        end
        // R2 multicast address
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h1234, 18, 1, 1, 1, 1, "R2");
        // R3 own address, R7 max duration
        send_frame(OWN_DA, 16'h8808, 16'h0001, 16'hFFFF, 18, 1, 1, 1, 1, "R3");
        // R3 last address byte differs
        send_frame({OWN_DA[47:8], 8'h70}, 16'h8808, 16'h0001, 16'h0BAD, 18, 1, 1, 1, 0, "R3");
        send_frame(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'h0BAD, 18, 1, 1, 1, 0, "R3");
        // R4 another source address (changes per frame), R7 zero duration
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h0000, 24, 1, 1, 1, 1, "R4");
        // R5 type
        send_frame(MC_DA, 16'h8809, 16'h0001, 16'h0BAD, 18, 1, 1, 1, 0, "R5");
        send_frame(MC_DA, 16'h0808, 16'h0001, 16'h0BAD, 18, 1, 1, 1, 0, "R5");
        // R6 opcode
        send_frame(MC_DA, 16'h8808, 16'h0002, 16'h0BAD, 18, 1, 1, 1, 0, "R6");
        send_frame(MC_DA, 16'h8808, 16'h0101, 16'h0BAD, 18, 1, 1, 1, 0, "R6");
        // R8 bad status
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h0BAD, 60, 0, 1, 1, 0, "R8");
        // R1 enables
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h0BAD, 18, 1, 0, 1, 0, "R1");
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h0BAD, 18, 1, 1, 0, 0, "R1");
        // R9 short and long frames
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h0BAD, 17, 1, 1, 1, 0, "R9");
        send_frame(OWN_DA, 16'h8808, 16'h0001, 16'h5A5A, 70, 1, 1, 1, 1, "R9");
        send_frame(MC_DA, 16'h8808, 16'h0001, 16'h00C7, 60, 1, 1, 1, 1, "R7");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual run hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule